// File: doc/BRIEF.md
# ADC code correction decoder

This block sits directly behind a converter and replaces each raw n-bit output code with the level that code really stands for. Manufacturing spreads the spacing between neighbouring reference levels. An external estimator therefore supplies one signed relative error per step, meaning the error in the distance from level i−1 to level i. The corrected value for code k is k plus the sum of the step errors from 1 to k. It is given in fixed point with 16 fractional bits and clamped to the unsigned output range. Level 0 is ground and always maps to zero.

Step errors are written into a shadow register file. A commit strobe then starts a sequential rebuild, one table entry per clock, into the idle half of a two-bank level table. When the last entry is written, the banks swap in a single clock. Until that swap, samples keep reading the previous table, so no sample ever sees a mixture of old and new levels. After reset, the block runs the same rebuild with all step errors forced to zero and clears the shadow file, so it comes up as an identity mapping. Samples arrive on a valid/ready stream and leave with a fixed latency.

Top module: `adc_code_corrector`

## Requirements
- R1: While reset is high, out_valid and in_ready are 0 and busy is 1. After reset, busy stays 1 until an identity table has been built. Once it falls, in_ready is 1 and code k yields k·2^16.
- R2: A sample accepted in cycle c (in_valid and in_ready both 1) gives out_valid = 1 in cycle c+2 and at no other time. out_valid is 0 in cycle c+1.
- R3: With step errors θ_i (signed, 20 bits, 16 fractional bits), code k yields k·2^16 + Σθ_i for i = 1..k on the 24-bit out_level. Code 0 always yields 0.
- R4: A corrected value below 0 is output as 0. A value above 2^24−1 is output as 2^24−1.
- R5: A par_we pulse with par_addr = i stores θ_i in the shadow file. The output does not change until a later commit.
- R6: A commit pulse while idle raises busy from the next cycle. busy stays high for exactly 2^8+1 = 257 cycles, and the new table is in use from the cycle busy falls.
- R7: While busy, every sample is corrected with the previous table. The swap to the new table happens in a single clock, at the same edge where busy falls.
- R8: A commit pulse while busy is ignored: it neither restarts nor lengthens the rebuild.
- R9: A parameter write while busy is ignored. The shadow file keeps its old value, which a later commit shows.
- R10: A parameter write to address 0 is ignored, and level 0 stays exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_we | input | 1 | Write strobe for one step error |
| par_addr | input | 8 | Step index i (1..255; 0 ignored) |
| par_data | input | 20 | Signed step error, 16 fractional bits |
| commit | input | 1 | Start rebuild from the shadow file |
| busy | output | 1 | Rebuild in progress |
| in_valid | input | 1 | Raw code valid |
| in_ready | output | 1 | Block accepts samples |
| in_code | input | 8 | Raw converter code |
| out_valid | output | 1 | Corrected sample valid |
| out_level | output | 24 | Corrected level, 16 fractional bits |

## Verification
Each corrected sample is due two clock edges after the edge that accepts it. The bench drives every sample just after one edge and checks that out_valid is still 0 just after the next edge, then reads the value just after the second edge. The rebuild is timed by counting the cycles busy stays high after the commit edge. During that count, a two-deep record of the driven samples is shifted once per cycle, so each output is matched against the code entered exactly two cycles earlier, under the table that was active when it was read.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} rb_state_t;
endpackage

// File: rtl/corr_sdp_ram.sv
module corr_sdp_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/corr_rebuild_ctrl.sv
module corr_rebuild_ctrl
  import adc_corr_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int FRAC_W  = 16,
  parameter int THETA_W = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit_i,
  output logic                      busy_o,
  output logic                      act_o,
  input  logic                      usr_we_i,
  input  logic [CODE_W-1:0]         usr_addr_i,
  input  logic [THETA_W-1:0]        usr_data_i,
  output logic                      pram_we,
  output logic [CODE_W-1:0]         pram_waddr,
  output logic [THETA_W-1:0]        pram_wdata,
  output logic [CODE_W-1:0]         pram_raddr,
  input  logic [THETA_W-1:0]        pram_rdata,
  output logic                      lvl_we,
  output logic [CODE_W:0]           lvl_waddr,
  output logic [CODE_W+FRAC_W-1:0]  lvl_wdata
);
  localparam int OUT_W = CODE_W + FRAC_W;
  localparam int ACC_W = THETA_W + CODE_W;
  localparam int LVL_W = ((ACC_W > OUT_W) ? ACC_W : OUT_W) + 2;
  localparam logic signed [LVL_W-1:0] MAX_LVL = LVL_W'((64'd1 << OUT_W) - 64'd1);

  rb_state_t                 st;
  logic                      init_q;
  logic [CODE_W:0]           cnt;
  logic                      p_vld;
  logic [CODE_W-1:0]         p_idx;
  logic signed [ACC_W-1:0]   acc;
  logic                      act_q;

  logic                      issue;
  logic                      last_wr;
  logic signed [THETA_W-1:0] theta_s;
  logic signed [ACC_W-1:0]   theta_ext;
  logic signed [ACC_W-1:0]   sum_now;
  logic signed [LVL_W-1:0]   base_lvl;
  logic signed [LVL_W-1:0]   lvl_full;

  assign busy_o  = (st == ST_RUN);
  assign act_o   = act_q;
  assign issue   = (st == ST_RUN) && !cnt[CODE_W];
  assign last_wr = p_vld && (p_idx == '1);
  assign theta_s = $signed(pram_rdata);

  // shadow file port: zero-fill during the reset rebuild, else user writes when idle
  always_comb begin
    if (init_q) begin
      pram_we    = issue;
      pram_waddr = cnt[CODE_W-1:0];
      pram_wdata = '0;
    end else begin
      pram_we    = usr_we_i && (st == ST_IDLE) && (usr_addr_i != '0);
      pram_waddr = usr_addr_i;
      pram_wdata = usr_data_i;
    end
  end
  assign pram_raddr = cnt[CODE_W-1:0];

  // running prefix sum and clamped level for the entry being written
  always_comb begin
    theta_ext = init_q ? '0 : ACC_W'(theta_s);
    sum_now   = (p_idx == '0) ? '0 : acc + theta_ext;
    base_lvl  = '0;
    base_lvl[FRAC_W +: CODE_W] = p_idx;
    lvl_full  = base_lvl + LVL_W'(sum_now);
    if (lvl_full < 0)             lvl_wdata = '0;
    else if (lvl_full > MAX_LVL)  lvl_wdata = '1;
    else                          lvl_wdata = lvl_full[OUT_W-1:0];
  end

  assign lvl_we    = p_vld;
  assign lvl_waddr = {~act_q, p_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_RUN;
      init_q <= 1'b1;
      cnt    <= '0;
      p_vld  <= 1'b0;
      p_idx  <= '0;
      acc    <= '0;
      act_q  <= 1'b0;
    end else begin
      p_vld <= issue;
      p_idx <= cnt[CODE_W-1:0];
      if (issue) cnt <= cnt + 1'b1;
      if (p_vld) acc <= sum_now;
      if ((st == ST_IDLE) && commit_i) begin
        st  <= ST_RUN;
        cnt <= '0;
      end
      if (last_wr) begin
        st     <= ST_IDLE;
        act_q  <= ~act_q;
        init_q <= 1'b0;
      end
    end
  end

  // R3: the entry for code 0 is always written as exactly zero
  p_level0_exact_r3: assert property (@(posedge clk) disable iff (rst)
    (lvl_we && (lvl_waddr[CODE_W-1:0] == '0)) |-> (lvl_wdata == '0));

  // R7: the active bank flips exactly when busy falls
  p_swap_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (act_q != $past(act_q)));

  // R7: the active bank holds while busy does not change
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(busy_o) |-> $stable(act_q));

  // R8: a commit during a rebuild does not rewind the walk
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && commit_i) |=> (cnt != '0));
endmodule

// File: rtl/adc_code_corrector.sv
module adc_code_corrector #(
  parameter int CODE_W  = 8,
  parameter int FRAC_W  = 16,
  parameter int THETA_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     par_we,
  input  logic [CODE_W-1:0]        par_addr,
  input  logic [THETA_W-1:0]       par_data,
  input  logic                     commit,
  output logic                     busy,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CODE_W-1:0]        in_code,
  output logic                     out_valid,
  output logic [CODE_W+FRAC_W-1:0] out_level
);
  localparam int OUT_W = CODE_W + FRAC_W;

  logic               pram_we;
  logic [CODE_W-1:0]  pram_waddr;
  logic [THETA_W-1:0] pram_wdata;
  logic [CODE_W-1:0]  pram_raddr;
  logic [THETA_W-1:0] pram_rdata;
  logic               lvl_we;
  logic [CODE_W:0]    lvl_waddr;
  logic [OUT_W-1:0]   lvl_wdata;
  logic [OUT_W-1:0]   lvl_rdata;
  logic               act_bank;
  logic               rdy_q;
  logic               v1_q;

  corr_rebuild_ctrl #(
    .CODE_W (CODE_W),
    .FRAC_W (FRAC_W),
    .THETA_W(THETA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .busy_o    (busy),
    .act_o     (act_bank),
    .usr_we_i  (par_we),
    .usr_addr_i(par_addr),
    .usr_data_i(par_data),
    .pram_we   (pram_we),
    .pram_waddr(pram_waddr),
    .pram_wdata(pram_wdata),
    .pram_raddr(pram_raddr),
    .pram_rdata(pram_rdata),
    .lvl_we    (lvl_we),
    .lvl_waddr (lvl_waddr),
    .lvl_wdata (lvl_wdata)
  );

  corr_sdp_ram #(.ADDR_W(CODE_W), .DATA_W(THETA_W)) u_shadow (
    .clk  (clk),
    .we   (pram_we),
    .waddr(pram_waddr),
    .wdata(pram_wdata),
    .raddr(pram_raddr),
    .rdata(pram_rdata)
  );

  // two banks of levels, the upper address bit selects the bank
  corr_sdp_ram #(.ADDR_W(CODE_W + 1), .DATA_W(OUT_W)) u_levels (
    .clk  (clk),
    .we   (lvl_we),
    .waddr(lvl_waddr),
    .wdata(lvl_wdata),
    .raddr({act_bank, in_code}),
    .rdata(lvl_rdata)
  );

  assign in_ready = rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b0;
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
      out_level <= '0;
    end else begin
      rdy_q     <= 1'b1;
      v1_q      <= in_valid && rdy_q;
      out_valid <= v1_q;
      out_level <= lvl_rdata;
    end
  end

  // R2: every accepted sample leaves exactly two edges later
  p_fixed_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && in_ready, 2));

  // R1: no sample is accepted in the first cycle after reset
  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> !out_valid);
endmodule

// File: tb/sim_adc_code_corrector.sv
`timescale 1ns/1ps
module sim_adc_code_corrector;
  logic        clk = 1'b0;
  logic        rst;
  logic        par_we;
  logic [7:0]  par_addr;
  logic [19:0] par_data;
  logic        commit;
  logic        busy;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_code;
  logic        out_valid;
  logic [23:0] out_level;

  int n_chk = 0;
  int n_bad = 0;
  int th_act [256];
  int th_sh  [256];

  localparam int NVEC = 12;
  localparam int VEC_CODE [NVEC] = '{0, 1, 2, 3, 4, 5, 100, 127, 128, 200, 254, 255};

  always #4 clk = ~clk;

  adc_code_corrector u0 (
    .clk(clk), .rst(rst), .par_we(par_we), .par_addr(par_addr), .par_data(par_data),
    .commit(commit), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_level(out_level)
  );

  function automatic longint exp_lvl(int k);
    longint s = longint'(k) * 65536;
    for (int i = 1; i <= k; i++) s += th_act[i];
    if (s < 0) s = 0;
    if (s > 16777215) s = 16777215;
    return s;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample(int code, string tag);
    in_valid = 1'b1;
    in_code  = 8'(code);
    step();
    in_valid = 1'b0;
    chk({tag, " R2 out_valid low after one edge"}, out_valid, 0);
    step();
    chk({tag, " R2 out_valid after two edges"}, out_valid, 1);
    chk(tag, out_level, exp_lvl(code));
  endtask

  task automatic wpar(int i, int v);
    par_we   = 1'b1;
    par_addr = 8'(i);
    par_data = 20'(v);
    step();
    par_we = 1'b0;
    if (i != 0) th_sh[i] = v;
  endtask

  task automatic commit_run(bit probe);
    int n;
    bit pv0, pv1;
    int pc0, pc1;
    pv0 = 0; pv1 = 0; pc0 = 0; pc1 = 0;
    commit = 1'b1;
    step();
    commit = 1'b0;
    chk("R6 busy after commit", busy, 1);
    n = 1;
    while (busy && n < 1000) begin
      if (probe && pv1) chk("R7 old table during rebuild", out_level, exp_lvl(pc1));
      pv1 = pv0; pc1 = pc0;
      if (probe && n < 200) begin
        in_valid = 1'b1; in_code = 8'(n); pv0 = 1; pc0 = n % 256;
      end else begin
        in_valid = 1'b0; pv0 = 0;
      end
      commit = (probe && n == 100);
      if (probe && n == 120) begin
        par_we = 1'b1; par_addr = 8'd7; par_data = 20'h3FFFF;
      end else par_we = 1'b0;
      step();
      n++;
    end
    in_valid = 1'b0; commit = 1'b0; par_we = 1'b0;
    chk(probe ? "R6 R8 busy length with commit while busy" : "R6 busy length", n - 1, 257);
    for (int i = 0; i < 256; i++) th_act[i] = th_sh[i];
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R6 run did not finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    for (int i = 0; i < 256; i++) begin th_act[i] = 0; th_sh[i] = 0; end
    rst = 1'b1; par_we = 1'b0; par_addr = '0; par_data = '0;
    commit = 1'b0; in_valid = 1'b0; in_code = '0;
    repeat (4) step();
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 0);
    chk("R1 busy in reset", busy, 1);
    rst = 1'b0;
    w = 0;
    while (busy && w < 1000) begin step(); w++; end
    chk("R1 busy falls after reset rebuild", busy, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    sample(0, "R1 identity code 0");
    sample(37, "R1 identity code 37");
    sample(255, "R1 identity code 255");

    // pattern A: step errors cycle through -0.25, 0, +0.25, +0.5
    for (int i = 1; i < 256; i++) wpar(i, ((i % 4) - 1) * 16384);
    sample(10, "R5 no effect before commit");
    commit_run(1'b1);

    for (int v = 0; v < NVEC; v++) sample(VEC_CODE[v], "R3 R4 vector");

    // write to step 7 during the rebuild must not have landed
    commit_run(1'b0);
    sample(7, "R9 write while busy ignored");
    sample(6, "R3 pattern A code 6");

    // pattern B: large dip at step 1, write to address 0 attempted
    wpar(0, 524287);
    wpar(1, -131072);
    for (int i = 2; i < 256; i++) wpar(i, 0);
    commit_run(1'b0);
    sample(0, "R10 level 0 exact after address 0 write");
    sample(1, "R4 clamp below zero");
    sample(2, "R3 pattern B code 2");
    sample(3, "R3 pattern B code 3");
    sample(255, "R3 pattern B code 255");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule